// File: doc/BRIEF.md
# Fractional-rate timebase counter

This block keeps a free-running count that advances at a fixed rate below that of its reference clock. The step rate is the rational fraction num/den of the reference frequency. A remainder accumulator carries the fraction left over from cycle to cycle, so over any run of den reference cycles the count advances by exactly num. Because of this the long-term rate has no rounding error. Software sets the two 12-bit ratio fields and reads the count through a small register bus.

The count is twice the bus half-width, which gives 64 bits by default, and it is read as two halves. A read of the low half also captures the high half of the same value. The following read of the high half therefore returns a matching pair even if a carry has occurred between the two reads. A separate resync pulse models the correction from a slow coarse clock: it discards the fractional remainder.

Some combinations of reference clock and ratio that give a 6.144 MHz count:

| Reference clock | num/den |
|---|---|
| 12 MHz | 64/125 |
| 13 MHz | 768/1625 |
| 19.2 MHz | 8/25 |
| 20 MHz | 192/625 |
| 26 MHz | 384/1625 |
| 27 MHz | 256/1125 |
| 38.4 MHz | 4/25 |

The ratio 75/244 serves as a fallback when the slow clock is itself derived from the system clock.

Top module: `frac_timebase`

## Requirements
- R1: A synchronous reset, active while `rst_n` is low, clears the count, the accumulator and both full 32-bit ratio registers.
- R2: The numerator register is at address 0x10 and the denominator register is at 0x14. The ratio field is bits 11:0 of each register. Bits 31:12 are stored exactly as written, read back unchanged and have no effect on the rate.
- R3: While den is nonzero, num < den, and no ratio write or resync occurs, each reference cycle adds num to the accumulator. When the sum is at least den, den is subtracted and the count advances by 1. Over den such cycles the count therefore advances by exactly num. This holds for 8/25, 768/1625 and 75/244.
- R4: When num >= den and den is nonzero, the count advances by 1 on every cycle and the accumulator is held at 0.
- R5: When den = 0, the count holds its value.
- R6: A write to either ratio register clears the accumulator, and the count does not advance on the cycle of that write.
- R7: A cycle with `resync_i` high clears the accumulator, and the count does not advance on that cycle.
- R8: A read of address 0x00 returns the low half of the count and captures the high half of the same value. A read of 0x04 returns the captured high half. Read data appears on `reg_rdata` one cycle after `reg_rd`, zero-extended, and holds until the next read.
- R9: A write to any address other than 0x10 or 0x14 changes neither the count, the accumulator nor any register.
- R10: A read of an address outside 0x00, 0x04, 0x10 and 0x14 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wdata | input | BUS_W (32) | Write data |
| reg_rdata | output | BUS_W (32) | Read data, valid the cycle after `reg_rd` |
| resync_i | input | 1 | Coarse correction pulse, clears the remainder |
| count_o | output | 2*HALF_W (64) | Live count value |

## Verification
The critical coincidence is a read of the low half on the same cycle that the count carries out of its low half. The captured high half must belong to the value read before the carry, not to the value after it. The bench narrows each half to 8 bits, makes the count step on every cycle, and alternates low and high reads across many carries. It checks each read-data value against a behavioural model that takes one snapshot per low read. A second coincidence, a ratio write on the same cycle as a resync, is also applied and judged by the same model.

// File: rtl/frac_tb_pkg.sv
package frac_tb_pkg;
    localparam logic [7:0] ADDR_CNT_LO = 8'h00;
    localparam logic [7:0] ADDR_CNT_HI = 8'h04;
    localparam logic [7:0] ADDR_NUM    = 8'h10;
    localparam logic [7:0] ADDR_DEN    = 8'h14;
endpackage

// File: rtl/frac_ratio_regs.sv
module frac_ratio_regs
    import frac_tb_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int FIELD_W = 12,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    output logic [BUS_W-1:0]   num_reg,
    output logic [BUS_W-1:0]   den_reg,
    output logic [FIELD_W-1:0] num_fld,
    output logic [FIELD_W-1:0] den_fld,
    output logic               ratio_wr
);
    typedef struct packed {
        logic [BUS_W-1:0] num;
        logic [BUS_W-1:0] den;
    } regs_t;

    regs_t s_d, s_q;
    logic  hit_num, hit_den;

    always_comb begin
        hit_num = wr_en && (wr_addr == ADDR_W'(ADDR_NUM));
        hit_den = wr_en && (wr_addr == ADDR_W'(ADDR_DEN));
        s_d = s_q;
        if (hit_num) s_d.num = wr_data;
        if (hit_den) s_d.den = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign num_reg  = s_q.num;
    assign den_reg  = s_q.den;
    assign num_fld  = s_q.num[FIELD_W-1:0];
    assign den_fld  = s_q.den[FIELD_W-1:0];
    assign ratio_wr = hit_num || hit_den;
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
    parameter int FIELD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] num,
    input  logic [FIELD_W-1:0] den,
    input  logic               clr,
    output logic               step,
    output logic [FIELD_W-1:0] acc
);
    typedef struct packed {
        logic [FIELD_W-1:0] acc;
    } acc_t;

    acc_t             s_d, s_q;
    logic [FIELD_W:0] sum;
    logic [FIELD_W:0] den_x;

    always_comb begin
        sum   = {1'b0, s_q.acc} + {1'b0, num};
        den_x = {1'b0, den};
        s_d   = s_q;
        step  = 1'b0;
        if (clr) begin
            s_d.acc = '0;
        end else if (den == '0) begin
            s_d = s_q;
        end else if (num >= den) begin
            step    = 1'b1;
            s_d.acc = '0;
        end else if (sum >= den_x) begin
            step    = 1'b1;
            s_d.acc = FIELD_W'(sum - den_x);
        end else begin
            s_d.acc = sum[FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc = s_q.acc;
endmodule

// File: rtl/frac_count_core.sv
module frac_count_core
    import frac_tb_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BUS_W-1:0]  num_reg,
    input  logic [BUS_W-1:0]  den_reg,
    output logic [CNT_W-1:0]  count,
    output logic [BUS_W-1:0]  rdata
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] hi;
        logic [BUS_W-1:0]  rdata;
    } core_t;

    core_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step) s_d.cnt = s_q.cnt + 1'b1;
        if (rd_en) begin
            case (rd_addr)
                ADDR_W'(ADDR_CNT_LO): begin
                    s_d.rdata = BUS_W'(s_q.cnt[HALF_W-1:0]);
                    s_d.hi    = s_q.cnt[CNT_W-1:HALF_W];
                end
                ADDR_W'(ADDR_CNT_HI): s_d.rdata = BUS_W'(s_q.hi);
                ADDR_W'(ADDR_NUM):    s_d.rdata = num_reg;
                ADDR_W'(ADDR_DEN):    s_d.rdata = den_reg;
                default:              s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign rdata = s_q.rdata;
endmodule

// File: rtl/frac_timebase.sv
module frac_timebase #(
    parameter int HALF_W  = 32,
    parameter int FIELD_W = 12,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 8,
    localparam int CNT_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              resync_i,
    output logic [CNT_W-1:0]  count_o
);
    logic [BUS_W-1:0]   num_reg, den_reg;
    logic [FIELD_W-1:0] num_fld, den_fld, acc_val;
    logic               ratio_wr, step;

    frac_ratio_regs #(.BUS_W(BUS_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .num_reg(num_reg), .den_reg(den_reg),
        .num_fld(num_fld), .den_fld(den_fld), .ratio_wr(ratio_wr)
    );

    frac_phase_acc #(.FIELD_W(FIELD_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .num(num_fld), .den(den_fld),
        .clr(ratio_wr || resync_i), .step(step), .acc(acc_val)
    );

    frac_count_core #(.HALF_W(HALF_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step(step), .rd_en(reg_rd),
        .rd_addr(reg_addr), .num_reg(num_reg), .den_reg(den_reg),
        .count(count_o), .rdata(reg_rdata)
    );
endmodule

// File: rtl/frac_timebase_chk.sv
module frac_timebase_chk
    import frac_tb_pkg::*;
#(
    parameter int HALF_W  = 32,
    parameter int FIELD_W = 12,
    parameter int ADDR_W  = 8,
    localparam int CNT_W  = 2 * HALF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               resync_i,
    input logic [CNT_W-1:0]   count_o,
    input logic [FIELD_W-1:0] num_fld,
    input logic [FIELD_W-1:0] den_fld,
    input logic [FIELD_W-1:0] acc_val
);
    logic [CNT_W-1:0] cnt_plus;
    logic             wr_ratio;
    assign cnt_plus = count_o + 1'b1;
    assign wr_ratio = reg_wr && (reg_addr == ADDR_W'(ADDR_NUM) || reg_addr == ADDR_W'(ADDR_DEN));

    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count_o == $past(count_o) || count_o == $past(cnt_plus))); // R3
    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (den_fld != '0) |-> (acc_val < den_fld)); // R3
    AST_FAST_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (den_fld != '0 && num_fld >= den_fld && !wr_ratio && !resync_i) |=> (count_o == $past(cnt_plus))); // R4
    AST_DEN_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (den_fld == '0) |=> $stable(count_o)); // R5
    AST_WRITE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ratio |=> $stable(count_o)); // R6
    AST_RESYNC_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> $stable(count_o)); // R7
endmodule

bind frac_timebase frac_timebase_chk #(.HALF_W(HALF_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .resync_i(resync_i), .count_o(count_o), .num_fld(num_fld),
    .den_fld(den_fld), .acc_val(acc_val)
);

// File: tb/tb_frac_timebase.sv
`timescale 1ns/1ps
module tb_frac_timebase;
    localparam int HW = 8;
    localparam int CW = 2 * HW;
    localparam int CMASK = (1 << CW) - 1;
    localparam int HMASK = (1 << HW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, resync_i = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [CW-1:0] count_o;

    frac_timebase #(.HALF_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .resync_i(resync_i), .count_o(count_o)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0, n_bad = 0, n_cyc = 0;
    string cur_req = "R1";
    int m_cnt = 0, m_acc = 0, m_hil = 0;
    logic [31:0] m_num = 0, m_den = 0, m_rd = 0;
    bit done = 0;

    always @(posedge clk) begin : model
        int n, d;
        bit hit;
        n_cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_acc = 0; m_num = 0; m_den = 0; m_hil = 0; m_rd = 0;
        end else begin
            n = int'(m_num[11:0]);
            d = int'(m_den[11:0]);
            if (reg_rd) begin
                case (reg_addr)
                    8'h00: begin m_rd = m_cnt & HMASK; m_hil = (m_cnt >> HW) & HMASK; end
                    8'h04: m_rd = m_hil;
                    8'h10: m_rd = m_num;
                    8'h14: m_rd = m_den;
                    default: m_rd = 0;
                endcase
            end
            hit = reg_wr && (reg_addr == 8'h10 || reg_addr == 8'h14);
            if (hit) begin
                if (reg_addr == 8'h10) m_num = reg_wdata; else m_den = reg_wdata;
                m_acc = 0;
            end else if (resync_i) m_acc = 0;
            else if (d == 0) m_acc = m_acc;
            else if (n >= d) begin m_cnt = (m_cnt + 1) & CMASK; m_acc = 0; end
            else begin
                m_acc += n;
                if (m_acc >= d) begin m_acc -= d; m_cnt = (m_cnt + 1) & CMASK; end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check(string req, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(logic w, logic r, logic [7:0] a, logic [31:0] wd, logic rs);
        @(negedge clk);
        check({cur_req, " count"}, longint'(count_o), longint'(m_cnt));
        check({cur_req, " rdata"}, longint'(reg_rdata), longint'(m_rd));
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd; resync_i = rs;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) cyc(0, 0, 8'h0, 32'h0, 0);
    endtask

    task automatic rate(int num, int den, int span, string req);
        int c0;
        cur_req = req;
        cyc(1, 0, 8'h10, 32'(num), 0);
        cyc(1, 0, 8'h14, 32'(den), 0);
        cyc(0, 0, 8'h0, 32'h0, 0);
        c0 = int'(count_o);
        idle(span);
        check({req, " rate"}, longint'((int'(count_o) - c0) & CMASK),
              longint'((num * span / den) & CMASK));
    endtask

    always @(posedge clk) begin
        if (n_cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", n_cyc);
            summary();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        cyc(0, 1, 8'h10, 0, 0);
        cyc(0, 1, 8'h14, 0, 0);
        idle(1);
        check("R1 count after reset", longint'(count_o), 0);
        // R2: upper bits stored, field sets the rate
        cur_req = "R2";
        cyc(1, 0, 8'h10, 32'hABCDE008, 0);
        cyc(1, 0, 8'h14, 32'h12345019, 0);
        cyc(0, 1, 8'h10, 0, 0);
        cyc(0, 1, 8'h14, 0, 0);
        check("R2 num readback", longint'(reg_rdata), longint'(32'hABCDE008));
        idle(1);
        check("R2 den readback", longint'(reg_rdata), longint'(32'h12345019));
        // R3: exact rates
        rate(8, 25, 2500, "R3");
        rate(768, 1625, 1625, "R3");
        rate(75, 244, 2440, "R3");
        // R6: write mid-accumulation
        cur_req = "R6";
        for (int i = 0; i < 40; i++) begin
            idle(i % 7);
            cyc(1, 0, (i % 2) ? 8'h14 : 8'h10, (i % 2) ? 32'd244 : 32'd75, 0);
        end
        // R7: resync pulses, plus collision with a ratio write
        cur_req = "R7";
        for (int i = 0; i < 60; i++) begin
            idle(i % 5);
            cyc(0, 0, 8'h0, 0, 1);
        end
        cyc(1, 0, 8'h10, 32'd64, 1);
        cyc(1, 0, 8'h14, 32'd125, 1);
        idle(300);
        // R4 and R8: step every cycle, coherent half reads across carries
        cur_req = "R4";
        cyc(1, 0, 8'h10, 32'd5, 0);
        cyc(1, 0, 8'h14, 32'd5, 0);
        idle(50);
        cur_req = "R8";
        for (int i = 0; i < 700; i++) begin
            cyc(0, 1, 8'h00, 0, 0);
            cyc(0, 1, 8'h04, 0, 0);
        end
        for (int i = 0; i < 100; i++) cyc(0, 1, (i % 3 == 0) ? 8'h00 : 8'h04, 0, 0);
        // R9: writes to other addresses are ignored
        cur_req = "R9";
        cyc(1, 0, 8'h00, 32'hFFFFFFFF, 0);
        cyc(1, 0, 8'h04, 32'hFFFFFFFF, 0);
        cyc(1, 0, 8'h18, 32'hFFFFFFFF, 0);
        idle(20);
        // R10: unmapped read returns zero
        cur_req = "R10";
        cyc(0, 1, 8'h10, 0, 0);
        cyc(0, 1, 8'h20, 0, 0);
        idle(1);
        check("R10 unmapped read", longint'(reg_rdata), 0);
        // R5: zero denominator holds the count
        cur_req = "R5";
        cyc(1, 0, 8'h14, 32'hFFFFF000, 0);
        idle(1);
        begin
            int held;
            held = int'(count_o);
            idle(200);
            check("R5 hold", longint'(count_o), longint'(held));
        end
        // R1: reset mid-run clears everything
        cur_req = "R1";
        cyc(1, 0, 8'h14, 32'd7, 0);
        idle(30);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        cyc(0, 1, 8'h14, 0, 0);
        idle(2);
        check("R1 den after reset", longint'(reg_rdata), 0);
        done = 1;
        summary();
    end
endmodule